// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This unit carries out the move-to and move-from special-purpose-register operations of a 32-bit processor core. For each access the core presents an address, a read strobe, a write strobe, write data and two status bits: the supervisor bit and the user-read-access bit. The unit holds the architectural system registers that such instructions reach. These are the status register, the floating-point control word, the exception PC, the exception status copy and the two halves of a multiply accumulator. It also holds a window of 512 shadow general-purpose registers, mapped into block RAM.

Read data and the fault indication are registered and appear one cycle after the strobe. Writes commit on the clock edge and are visible on the state outputs one cycle later. Writing the status register forces its fixed-one bit. Writing the next-PC address stores nothing and instead sends a one-cycle redirect pulse that carries the new PC and clears any pending delay slot. The timer-mode address only accepts a write of zero. Any refused or unmapped access yields zero read data, drops the write and pulses a fault flag with a cause code. The identification registers return constant values set by parameters.

Top module: `spr_access_unit`

## Requirements
- R1: An access made while both `sm_i` and `sumra_i` are 0 is refused: a read returns 0, a write changes no state, and `err_o` pulses with `err_cause_o` = 1. Either bit alone grants access. The privilege cause takes priority over all other causes.
- R2: An address at or above `NUM_SPR` (default 0x600), or an address that maps to no register, is refused: read data 0, write dropped, `err_o` with `err_cause_o` = 2.
- R3: Readable addresses are 0x000 version, 0x001 unit-present, 0x002 config (all three return their parameter values), 0x011 status, 0x012 previous PC (returns `prev_pc_i`), 0x014 FP control, 0x020 exception PC, 0x080 accumulator low, 0x082 accumulator high, and the GPR window. A read of the write-only addresses 0x010 next-PC, 0x030 exception status or 0x050 timer mode is refused with cause 2.
- R4: Writable addresses are 0x010, 0x011, 0x014, 0x020, 0x030, 0x050, 0x080, 0x082 and the GPR window. A write to 0x000, 0x001, 0x002 or 0x012 is refused with cause 2 and changes no state.
- R5: A write to the status register stores the data with bit 15 (the fixed-one bit) forced to 1.
- R6: A write to 0x010 stores no register. In the next cycle `redirect_o` is 1 for exactly one cycle and `redirect_pc_o` holds the written value.
- R7: A write of zero to timer mode 0x050 is accepted with no fault. A nonzero write is refused with `err_cause_o` = 3 and has no effect.
- R8: The GPR window covers addresses 0x400..0x5FF, one 32-bit entry per address, and each entry can be read and written.
- R9: `rd_data_o`, `err_o`, `err_cause_o` and `redirect_o` are valid in the cycle after the strobe. If any part of an access faults, the whole access is refused. A read and a write to the same address in the same cycle return the old value.
- R10: After reset the status register holds 0x00008001, all other system registers hold 0, and `rd_data_o`, `err_o`, `err_cause_o` and `redirect_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| sm_i | input | 1 | Supervisor mode status bit |
| sumra_i | input | 1 | User read-access status bit |
| prev_pc_i | input | DATA_W | Previous PC from the pipeline |
| rd_data_o | output | DATA_W | Read data, one cycle after the strobe |
| err_o | output | 1 | One-cycle fault pulse |
| err_cause_o | output | 2 | Fault cause: 0 none, 1 privilege, 2 address, 3 value |
| redirect_o | output | 1 | One-cycle PC redirect pulse, also clears delay-slot state |
| redirect_pc_o | output | DATA_W | Redirect target |
| sr_o | output | DATA_W | Status register |
| fp_ctrl_o | output | DATA_W | Floating-point control word |
| exc_pc_o | output | DATA_W | Exception PC |
| exc_sr_o | output | DATA_W | Exception status copy |
| acc_lo_o | output | DATA_W | Accumulator low half |
| acc_hi_o | output | DATA_W | Accumulator high half |

## Verification
The assertions take the strobes and status bits to be low while reset is active. This keeps the one-cycle look-back in the properties meaningful on the first cycle after reset. They also take the GPR base to be aligned to the window size, so the low address bits index the RAM directly. The stimulus holds every strobe low during and right after reset and uses only the default aligned map. Each access is driven for one cycle and followed by an idle cycle, so a fault or redirect pulse from one access never overlaps the next access. Before the random phase every GPR entry is written once, so that reads never return uninitialised RAM.

// File: rtl/spr_pkg.sv
package spr_pkg;

  // Address map (word-granular register addresses)
  localparam int unsigned A_VERSION  = 32'h000;
  localparam int unsigned A_UNITS    = 32'h001;
  localparam int unsigned A_CONFIG   = 32'h002;
  localparam int unsigned A_NEXT_PC  = 32'h010;
  localparam int unsigned A_STATUS   = 32'h011;
  localparam int unsigned A_PREV_PC  = 32'h012;
  localparam int unsigned A_FP_CTRL  = 32'h014;
  localparam int unsigned A_EXC_PC   = 32'h020;
  localparam int unsigned A_EXC_SR   = 32'h030;
  localparam int unsigned A_TMR_MODE = 32'h050;
  localparam int unsigned A_ACC_LO   = 32'h080;
  localparam int unsigned A_ACC_HI   = 32'h082;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_VERSION, SEL_UNITS, SEL_CONFIG, SEL_NEXT_PC, SEL_STATUS,
    SEL_PREV_PC, SEL_FP_CTRL, SEL_EXC_PC, SEL_EXC_SR, SEL_TMR_MODE,
    SEL_ACC_LO, SEL_ACC_HI, SEL_GPR
  } spr_sel_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_PRIV  = 2'd1,
    CAUSE_ADDR  = 2'd2,
    CAUSE_VALUE = 2'd3
  } spr_cause_e;

endpackage

// File: rtl/spr_decode.sv
module spr_decode
  import spr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_SPR   = 32'h600,
  parameter int GPR_BASE  = 32'h400,
  parameter int GPR_COUNT = 512
) (
  input  logic [ADDR_W-1:0] addr_i,
  output spr_sel_e          sel_o,
  output logic              rd_ok_o,
  output logic              wr_ok_o
);

  logic [31:0] a;

  always_comb begin
    a     = 32'(addr_i);
    sel_o = SEL_NONE;
    if (a < 32'(NUM_SPR)) begin
      if (a >= 32'(GPR_BASE) && a < 32'(GPR_BASE + GPR_COUNT)) sel_o = SEL_GPR;
      else begin
        case (a)
          A_VERSION:  sel_o = SEL_VERSION;
          A_UNITS:    sel_o = SEL_UNITS;
          A_CONFIG:   sel_o = SEL_CONFIG;
          A_NEXT_PC:  sel_o = SEL_NEXT_PC;
          A_STATUS:   sel_o = SEL_STATUS;
          A_PREV_PC:  sel_o = SEL_PREV_PC;
          A_FP_CTRL:  sel_o = SEL_FP_CTRL;
          A_EXC_PC:   sel_o = SEL_EXC_PC;
          A_EXC_SR:   sel_o = SEL_EXC_SR;
          A_TMR_MODE: sel_o = SEL_TMR_MODE;
          A_ACC_LO:   sel_o = SEL_ACC_LO;
          A_ACC_HI:   sel_o = SEL_ACC_HI;
          default:    sel_o = SEL_NONE;
        endcase
      end
    end
  end

  // Readable and writable sets differ (R3, R4)
  always_comb begin
    case (sel_o)
      SEL_VERSION, SEL_UNITS, SEL_CONFIG, SEL_STATUS, SEL_PREV_PC,
      SEL_FP_CTRL, SEL_EXC_PC, SEL_ACC_LO, SEL_ACC_HI, SEL_GPR: rd_ok_o = 1'b1;
      default: rd_ok_o = 1'b0;
    endcase
    case (sel_o)
      SEL_NEXT_PC, SEL_STATUS, SEL_FP_CTRL, SEL_EXC_PC, SEL_EXC_SR,
      SEL_TMR_MODE, SEL_ACC_LO, SEL_ACC_HI, SEL_GPR: wr_ok_o = 1'b1;
      default: wr_ok_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/spr_gpr_ram.sv
module spr_gpr_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Single port, read-first: a same-cycle read returns the old word
  always_ff @(posedge clk) begin
    if (we_i) mem[idx_i] <= wdata_i;
    q_o <= mem[idx_i];
  end

endmodule

// File: rtl/spr_sysregs.sv
module spr_sysregs
  import spr_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] VERSION   = 32'h0001_0000,
  parameter logic [31:0] UNITS     = 32'h0000_0001,
  parameter logic [31:0] CONFIG    = 32'h0000_0020,
  parameter logic [31:0] SR_RESET  = 32'h0000_8001,
  parameter int          FO_BIT    = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  spr_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] prev_pc_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] sr_o,
  output logic [DATA_W-1:0] fp_ctrl_o,
  output logic [DATA_W-1:0] exc_pc_o,
  output logic [DATA_W-1:0] exc_sr_o,
  output logic [DATA_W-1:0] acc_lo_o,
  output logic [DATA_W-1:0] acc_hi_o,
  output logic              redirect_o,
  output logic [DATA_W-1:0] redirect_pc_o
);

  localparam logic [DATA_W-1:0] FO_MASK = DATA_W'(1) << FO_BIT;

  logic [DATA_W-1:0] sr_q, fp_q, epc_q, esr_q, lo_q, hi_q, rpc_q;
  logic              redir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q    <= DATA_W'(SR_RESET);
      fp_q    <= '0;
      epc_q   <= '0;
      esr_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      rpc_q   <= '0;
      redir_q <= 1'b0;
    end else begin
      redir_q <= 1'b0;
      if (wr_i) begin
        case (sel_i)
          SEL_STATUS:  sr_q  <= wdata_i | FO_MASK;
          SEL_FP_CTRL: fp_q  <= wdata_i;
          SEL_EXC_PC:  epc_q <= wdata_i;
          SEL_EXC_SR:  esr_q <= wdata_i;
          SEL_ACC_LO:  lo_q  <= wdata_i;
          SEL_ACC_HI:  hi_q  <= wdata_i;
          SEL_NEXT_PC: begin
            redir_q <= 1'b1;
            rpc_q   <= wdata_i;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel_i)
      SEL_VERSION: rdata_o = DATA_W'(VERSION);
      SEL_UNITS:   rdata_o = DATA_W'(UNITS);
      SEL_CONFIG:  rdata_o = DATA_W'(CONFIG);
      SEL_STATUS:  rdata_o = sr_q;
      SEL_PREV_PC: rdata_o = prev_pc_i;
      SEL_FP_CTRL: rdata_o = fp_q;
      SEL_EXC_PC:  rdata_o = epc_q;
      SEL_ACC_LO:  rdata_o = lo_q;
      SEL_ACC_HI:  rdata_o = hi_q;
      default:     rdata_o = '0;
    endcase
  end

  assign sr_o          = sr_q;
  assign fp_ctrl_o     = fp_q;
  assign exc_pc_o      = epc_q;
  assign exc_sr_o      = esr_q;
  assign acc_lo_o      = lo_q;
  assign acc_hi_o      = hi_q;
  assign redirect_o    = redir_q;
  assign redirect_pc_o = rpc_q;

  assert_sr_fixed_one_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_i && sel_i == SEL_STATUS) |=> sr_q[FO_BIT]);

  assert_npc_no_store_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_i && sel_i == SEL_NEXT_PC) |=> ($stable(sr_q) && $stable(fp_q) &&
      $stable(epc_q) && $stable(esr_q) && $stable(lo_q) && $stable(hi_q)));

endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
  import spr_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 32,
  parameter int          NUM_SPR   = 32'h600,
  parameter int          GPR_BASE  = 32'h400,
  parameter int          GPR_COUNT = 512,
  parameter logic [31:0] VERSION   = 32'h0001_0000,
  parameter logic [31:0] UNITS     = 32'h0000_0001,
  parameter logic [31:0] CONFIG    = 32'h0000_0020,
  parameter logic [31:0] SR_RESET  = 32'h0000_8001,
  parameter int          FO_BIT    = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sm_i,
  input  logic              sumra_i,
  input  logic [DATA_W-1:0] prev_pc_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              err_o,
  output logic [1:0]        err_cause_o,
  output logic              redirect_o,
  output logic [DATA_W-1:0] redirect_pc_o,
  output logic [DATA_W-1:0] sr_o,
  output logic [DATA_W-1:0] fp_ctrl_o,
  output logic [DATA_W-1:0] exc_pc_o,
  output logic [DATA_W-1:0] exc_sr_o,
  output logic [DATA_W-1:0] acc_lo_o,
  output logic [DATA_W-1:0] acc_hi_o
);

  localparam int GPR_AW = $clog2(GPR_COUNT);

  spr_sel_e          sel;
  logic              rd_ok, wr_ok;
  logic              priv_ok, req, bad_addr, bad_val, fault;
  logic              commit_rd, commit_wr;
  spr_cause_e        cause;
  logic [DATA_W-1:0] sys_rdata, gpr_q;
  logic [DATA_W-1:0] rd_sys_q;
  logic              rd_gpr_q, err_q;
  spr_cause_e        cause_q;

  spr_decode #(
    .ADDR_W(ADDR_W), .NUM_SPR(NUM_SPR), .GPR_BASE(GPR_BASE), .GPR_COUNT(GPR_COUNT)
  ) u_decode (
    .addr_i (addr_i),
    .sel_o  (sel),
    .rd_ok_o(rd_ok),
    .wr_ok_o(wr_ok)
  );

  // Fault classification: privilege first, then address, then value
  always_comb begin
    priv_ok  = sm_i | sumra_i;
    req      = rd_en_i | wr_en_i;
    bad_addr = (rd_en_i & ~rd_ok) | (wr_en_i & ~wr_ok);
    bad_val  = wr_en_i & (sel == SEL_TMR_MODE) & (wdata_i != '0);
    fault    = req & (~priv_ok | bad_addr | bad_val);
    if (!priv_ok)      cause = CAUSE_PRIV;
    else if (bad_addr) cause = CAUSE_ADDR;
    else if (bad_val)  cause = CAUSE_VALUE;
    else               cause = CAUSE_NONE;
    commit_rd = rd_en_i & ~fault;
    commit_wr = wr_en_i & ~fault;
  end

  spr_sysregs #(
    .DATA_W(DATA_W), .VERSION(VERSION), .UNITS(UNITS), .CONFIG(CONFIG),
    .SR_RESET(SR_RESET), .FO_BIT(FO_BIT)
  ) u_sysregs (
    .clk          (clk),
    .rst          (rst),
    .wr_i         (commit_wr),
    .sel_i        (sel),
    .wdata_i      (wdata_i),
    .prev_pc_i    (prev_pc_i),
    .rdata_o      (sys_rdata),
    .sr_o         (sr_o),
    .fp_ctrl_o    (fp_ctrl_o),
    .exc_pc_o     (exc_pc_o),
    .exc_sr_o     (exc_sr_o),
    .acc_lo_o     (acc_lo_o),
    .acc_hi_o     (acc_hi_o),
    .redirect_o   (redirect_o),
    .redirect_pc_o(redirect_pc_o)
  );

  // GPR_BASE is aligned to GPR_COUNT, so the low bits index the window
  spr_gpr_ram #(.DATA_W(DATA_W), .DEPTH(GPR_COUNT)) u_gpr (
    .clk    (clk),
    .we_i   (commit_wr && sel == SEL_GPR),
    .idx_i  (addr_i[GPR_AW-1:0]),
    .wdata_i(wdata_i),
    .q_o    (gpr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sys_q <= '0;
      rd_gpr_q <= 1'b0;
      err_q    <= 1'b0;
      cause_q  <= CAUSE_NONE;
    end else begin
      rd_sys_q <= (commit_rd && sel != SEL_GPR) ? sys_rdata : '0;
      rd_gpr_q <= commit_rd && sel == SEL_GPR;
      err_q    <= fault;
      cause_q  <= fault ? cause : CAUSE_NONE;
    end
  end

  assign rd_data_o   = rd_gpr_q ? gpr_q : rd_sys_q;
  assign err_o       = err_q;
  assign err_cause_o = cause_q;

  assert_refused_read_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (err_o && $past(rd_en_i)) |-> rd_data_o == '0);

  assert_unpriv_write_dropped_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !sm_i && !sumra_i) |=> ($stable(sr_o) && $stable(exc_sr_o) &&
      $stable(fp_ctrl_o) && $stable(exc_pc_o) && !redirect_o));

  assert_high_addr_fault_R2: assert property (@(posedge clk) disable iff (rst)
    ((rd_en_i || wr_en_i) && (sm_i || sumra_i) && 32'(addr_i) >= 32'(NUM_SPR))
      |=> (err_o && err_cause_o == CAUSE_ADDR));

  assert_redirect_no_fault_R6: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> !err_o);

  assert_fault_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (!rd_en_i && !wr_en_i) |=> !err_o);

endmodule

// File: tb/spr_access_unit_bench.sv
`timescale 1ns/1ps
module spr_access_unit_bench;

  localparam logic [31:0] P_VER   = 32'h1203_0007;
  localparam logic [31:0] P_UNITS = 32'h0000_0615;
  localparam logic [31:0] P_CFG   = 32'h0000_0320;
  localparam int NUM   = 32'h600;
  localparam int GBASE = 32'h400;
  localparam int GCNT  = 512;

  logic clk = 1'b0, rst = 1'b1;
  logic rd_en = 0, wr_en = 0, sm = 0, sumra = 0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0, ppc = '0;
  logic [31:0] rd_data, redirect_pc, sr, fpc, epc, esr, alo, ahi;
  logic err, redirect;
  logic [1:0] cause;

  always #2 clk = ~clk;

  spr_access_unit #(.VERSION(P_VER), .UNITS(P_UNITS), .CONFIG(P_CFG)) u_spr_access_unit (
    .clk(clk), .rst(rst), .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .sm_i(sm), .sumra_i(sumra), .prev_pc_i(ppc),
    .rd_data_o(rd_data), .err_o(err), .err_cause_o(cause), .redirect_o(redirect),
    .redirect_pc_o(redirect_pc), .sr_o(sr), .fp_ctrl_o(fpc), .exc_pc_o(epc),
    .exc_sr_o(esr), .acc_lo_o(alo), .acc_hi_o(ahi)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Bench model
  logic [31:0] m_sr = 32'h0000_8001, m_fp = 0, m_epc = 0, m_esr = 0, m_lo = 0, m_hi = 0;
  logic [31:0] m_gpr [GCNT];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic bit in_gpr(input logic [15:0] a);
    return 32'(a) >= GBASE && 32'(a) < GBASE + GCNT;
  endfunction

  function automatic bit can_read(input logic [15:0] a);
    case (a)
      16'h000, 16'h001, 16'h002, 16'h011, 16'h012, 16'h014, 16'h020, 16'h080, 16'h082: return 1;
      default: return in_gpr(a);
    endcase
  endfunction

  function automatic bit can_write(input logic [15:0] a);
    case (a)
      16'h010, 16'h011, 16'h014, 16'h020, 16'h030, 16'h050, 16'h080, 16'h082: return 1;
      default: return in_gpr(a);
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [15:0] a, input logic [31:0] pp);
    case (a)
      16'h000: return P_VER;
      16'h001: return P_UNITS;
      16'h002: return P_CFG;
      16'h011: return m_sr;
      16'h012: return pp;
      16'h014: return m_fp;
      16'h020: return m_epc;
      16'h080: return m_lo;
      16'h082: return m_hi;
      default: return in_gpr(a) ? m_gpr[a[8:0]] : 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] c, input logic [15:0] a, input bit w);
    if (c == 2'd1) return "R1";
    if (c == 2'd3) return "R7";
    if (c == 2'd2) return (32'(a) >= NUM) ? "R2" : (w ? "R4" : "R3");
    if (in_gpr(a)) return "R8";
    if (w && a == 16'h011) return "R5";
    if (w && a == 16'h010) return "R6";
    return "R3";
  endfunction

  task automatic op(input bit r, input bit w, input logic [15:0] a, input logic [31:0] d,
                    input bit s, input bit u);
    logic [1:0] ec;
    logic [31:0] er;
    bit eredir;
    string t;
    logic [31:0] pp;
    pp = $urandom;
    ec = 2'd0;
    if (r || w) begin
      if (!(s || u)) ec = 2'd1;
      else if ((r && !can_read(a)) || (w && !can_write(a))) ec = 2'd2;
      else if (w && a == 16'h050 && d != 0) ec = 2'd3;
    end
    // R9: read returns the value before any same-cycle write
    er = (r && ec == 0) ? model_read(a, pp) : 32'h0;
    eredir = w && ec == 0 && a == 16'h010;
    if (w && ec == 0) begin
      case (a)
        16'h011: m_sr = d | 32'h0000_8000;
        16'h014: m_fp = d;
        16'h020: m_epc = d;
        16'h030: m_esr = d;
        16'h080: m_lo = d;
        16'h082: m_hi = d;
        default: if (in_gpr(a)) m_gpr[a[8:0]] = d;
      endcase
    end
    t = tag_of(ec, a, w);
    @(negedge clk);
    rd_en = r; wr_en = w; addr = a; wdata = d; sm = s; sumra = u; ppc = pp;
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    if (r) chk(t, "rd_data", rd_data, er);
    chk(t, "err", 32'(err), 32'(ec != 0));
    chk(t, "cause", 32'(cause), 32'(ec));
    chk(t, "redirect", 32'(redirect), 32'(eredir));
    if (eredir) chk("R6", "redirect_pc", redirect_pc, d);
    chk(t, "sr", sr, m_sr);
    chk(t, "fp_ctrl", fpc, m_fp);
    chk(t, "exc_pc", epc, m_epc);
    chk(t, "exc_sr", esr, m_esr);
    chk(t, "acc_lo", alo, m_lo);
    chk(t, "acc_hi", ahi, m_hi);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] regs [12];
    void'($urandom(32'd20240611));
    regs = '{16'h000, 16'h001, 16'h002, 16'h010, 16'h011, 16'h012,
             16'h014, 16'h020, 16'h030, 16'h050, 16'h080, 16'h082};
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    // R10: reset state
    chk("R10", "sr", sr, 32'h0000_8001);
    chk("R10", "fp_ctrl", fpc, 0);
    chk("R10", "exc_sr", esr, 0);
    chk("R10", "rd_data", rd_data, 0);
    chk("R10", "err", 32'(err), 0);
    chk("R10", "redirect", 32'(redirect), 0);

    // R3: identification and readable registers
    op(1, 0, 16'h000, 0, 1, 0);
    op(1, 0, 16'h001, 0, 0, 1);
    op(1, 0, 16'h002, 0, 1, 1);
    op(1, 0, 16'h012, 0, 1, 0);
    op(1, 0, 16'h011, 0, 1, 0);
    // R1: privilege refusal, read and write
    op(1, 0, 16'h011, 0, 0, 0);
    op(0, 1, 16'h030, 32'hDEAD_BEEF, 0, 0);
    op(0, 1, 16'h030, 32'hCAFE_0001, 0, 1);
    op(0, 1, 16'h700, 32'h1, 0, 0);
    // R2: high and hole addresses
    op(1, 0, 16'h600, 0, 1, 0);
    op(0, 1, 16'hFFFF, 32'h55, 1, 0);
    op(1, 0, 16'h003, 0, 1, 0);
    // R3: write-only reads refused
    op(1, 0, 16'h010, 0, 1, 0);
    op(1, 0, 16'h030, 0, 1, 0);
    op(1, 0, 16'h050, 0, 1, 0);
    // R4: read-only writes refused
    op(0, 1, 16'h000, 32'h1234, 1, 0);
    op(0, 1, 16'h012, 32'h1234, 1, 0);
    // R5: fixed-one bit forced
    op(0, 1, 16'h011, 32'h0, 1, 0);
    op(1, 0, 16'h011, 0, 1, 0);
    op(0, 1, 16'h011, 32'hFFFF_7FFE, 1, 0);
    // R6: next-PC redirect
    op(0, 1, 16'h010, 32'h0000_2000, 1, 0);
    op(0, 0, 16'h010, 0, 1, 0);
    // R7: timer-mode writes
    op(0, 1, 16'h050, 32'h0, 1, 0);
    op(0, 1, 16'h050, 32'h5, 1, 0);
    // R8: fill the whole GPR window, then read its ends
    for (int i = 0; i < GCNT; i++) op(0, 1, 16'(GBASE + i), $urandom, 1, 0);
    op(1, 0, 16'h400, 0, 1, 0);
    op(1, 0, 16'h5FF, 0, 0, 1);
    // R9: read and write same cycle returns old value
    op(1, 1, 16'h480, 32'hA5A5_0F0F, 1, 0);
    op(1, 0, 16'h480, 0, 1, 0);
    op(1, 1, 16'h020, 32'h0000_0444, 1, 0);
    op(1, 1, 16'h010, 32'h0000_0888, 1, 0);

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      logic [31:0] d;
      int k, pm;
      bit r, w, s, u;
      k = $urandom_range(0, 9);
      if (k <= 5) a = regs[$urandom_range(0, 11)];
      else if (k <= 7) a = 16'(GBASE + $urandom_range(0, GCNT - 1));
      else if (k == 8) a = 16'($urandom_range(NUM, 16'hFFFF));
      else a = 16'($urandom_range(0, GBASE - 1));
      d = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
      pm = $urandom_range(0, 3);
      r = pm[0]; w = pm[1];
      if (!r && !w) r = 1;
      k = $urandom_range(0, 7);
      s = (k != 0) && ($urandom_range(0, 1) == 1);
      u = (k != 0) && !s ? 1'b1 : 1'($urandom_range(0, 1));
      op(r, w, a, d, s, u);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule